// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous request port to an external asynchronous static RAM with 18-bit word addressing, a 16-bit data bus and two byte-lane enables. A requester presents one word access at a time through a valid/ready handshake. A read returns its word through a one-cycle response pulse. A write carries a per-lane mask that chooses which bytes of the stored word change. Every pin toward the RAM (select, output enable, write enable, byte enables, address, write data and data drive enable) comes straight from a flop.

All timing comes from counting clock cycles. Each RAM minimum is a parameter in nanoseconds, alongside the clock period parameter. The block rounds each minimum up to whole cycles and gives every nonzero minimum at least one cycle. After reset the block holds select inactive for a parameterised power-up interval before it accepts the first request. Between accesses it keeps select inactive for a minimum number of cycles.

The data bus is split into an output word, an output drive enable and an input word. The pad ring joins them into the bidirectional bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: From reset release, `ramSelN` stays high, `ramWeN` high, `ramDqOe` low and `reqReady` low for exactly ceil(T_PWRUP_NS/CLK_NS) clock edges. `reqReady` is first seen high after that many edges.
- R2: `reqReady` is high only while no RAM access or recovery gap is in progress. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. Request fields are sampled only on that edge.
- R3: A read (`reqWrite` = 0) drives `ramSelN` low, `ramOeN` low, `ramWeN` high and both byte enables low. These are held for exactly RD cycles, where RD is the largest of the rounded-up read-cycle, address-access and output-enable-access minima (18 at the defaults with a 4 ns clock).
- R4: The word present on `ramDqIn` in the last read strobe cycle is returned on `rspData`. `rspValid` is high for exactly one cycle, the first cycle after the strobes are released, RD+1 cycles after the accepting edge.
- R5: A write spends one setup cycle with `ramSelN` low, `ramDqOe` high and `ramWeN` high. It then holds `ramWeN` low for exactly WP cycles, where WP is the largest of the rounded-up write-pulse and data-setup minima, the select-to-end minimum less one cycle, and the write-cycle minimum less one cycle (17 at the defaults). Address and write data are stable throughout, and `ramSelN` rises on the same edge as `ramWeN`.
- R6: During a write, `ramByteEnN[0]` (data bits 7:0) is low exactly when mask bit 0 is set. `ramByteEnN[1]` (data bits 15:8) is low exactly when mask bit 1 is set. The byte of a disabled lane keeps its earlier value in the RAM.
- R7: A write with an all-zero mask is taken without any RAM cycle. Select and write enable stay high, and `reqReady` stays high.
- R8: After every access `ramSelN` stays high for at least GAP cycles before the next access, where GAP is the rounded-up select-high minimum (3 at the defaults).
- R9: `ramDqOe` is never high while `ramOeN` is low, and it is high during every cycle in which `ramWeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Write lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | One-cycle read data strobe |
| rspData | output | 16 | Read data |
| ramAddr | output | 18 | RAM address |
| ramSelN | output | 1 | RAM chip select, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramByteEnN | output | 2 | Byte enables, active low, bit 0 lower, bit 1 upper |
| ramDqOut | output | 16 | Data toward RAM |
| ramDqOe | output | 1 | Drive enable for the data bus |
| ramDqIn | input | 16 | Data from RAM |

## Verification
The assertions take nothing for granted about `ramDqIn`. They rely only on the request fields being sampled on the accepting edge, so a requester that changes address or data while an access runs cannot disturb the stability properties. They also rely on reset having been applied before the first edge at which they are evaluated. The stimulus raises `reqValid` only after it sees `reqReady` high, and withdraws it one cycle later. Addresses are drawn from a small pool that includes the lowest and highest word, so reads often hit data written earlier through masked writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Strobe set that the control hands to the datapath each cycle.
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
  } ram_strobe_t;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_READ   = 3'd2,
    ST_WSETUP = 3'd3,
    ST_WPULSE = 3'd4,
    ST_GAP    = 3'd5
  } ctrl_state_t;

  // Round a time up to whole clock cycles; zero stays zero.
  function automatic int nsToCycles(input int ns, input int periodNs);
    if (ns <= 0) return 0;
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC       = 18,
  parameter int WR_PULSE_CYC = 17,
  parameter int GAP_CYC      = 3,
  parameter int PWRUP_CYC    = 50000,
  parameter int CW           = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqMaskAny,
  output logic        reqReady,
  output ram_strobe_t stb,
  output logic        load,
  output logic        capture
);

  ctrl_state_t    state, nextState;
  logic [CW-1:0]  cnt, nextCnt;
  ram_strobe_t    nextStb;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    load      = 1'b0;
    capture   = 1'b0;
    unique case (state)
      ST_PWRUP: begin
        if (cnt == CW'(PWRUP_CYC - 1)) begin
          nextState = ST_IDLE;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_IDLE: begin
        if (reqValid) begin
          load    = 1'b1;
          nextCnt = '0;
          if (!reqWrite)       nextState = ST_READ;
          else if (reqMaskAny) nextState = ST_WSETUP;
        end
      end
      ST_READ: begin
        if (cnt == CW'(RD_CYC - 1)) begin
          capture   = 1'b1;
          nextState = ST_GAP;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_WSETUP: begin
        nextState = ST_WPULSE;
        nextCnt   = '0;
      end
      ST_WPULSE: begin
        if (cnt == CW'(WR_PULSE_CYC - 1)) begin
          nextState = ST_GAP;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == CW'(GAP_CYC - 1)) begin
          nextState = ST_IDLE;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      default: begin
        nextState = ST_PWRUP;
        nextCnt   = '0;
      end
    endcase
  end

  // Strobes are decoded from the next state and registered, so pins come from flops.
  always_comb begin
    nextStb = '0;
    unique case (nextState)
      ST_READ:   begin nextStb.sel = 1'b1; nextStb.oe = 1'b1; end
      ST_WSETUP: begin nextStb.sel = 1'b1; nextStb.drive = 1'b1; end
      ST_WPULSE: begin nextStb.sel = 1'b1; nextStb.drive = 1'b1; nextStb.we = 1'b1; end
      default:   nextStb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PWRUP;
      cnt   <= '0;
      stb   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      stb   <= nextStb;
    end
  end

  assign reqReady = (state == ST_IDLE);

  // Cycles with select released, saturating at the gap length (assertion support).
  logic [CW-1:0] selHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            selHighCnt <= '0;
    else if (stb.sel)                     selHighCnt <= '0;
    else if (selHighCnt < CW'(GAP_CYC))   selHighCnt <= selHighCnt + 1'b1;
  end

  // R8: select must have been released for the gap before it is taken again.
  a_r8_select_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.sel) |-> selHighCnt >= CW'(GAP_CYC));

  // R2: no request is offered while a strobe is active.
  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !stb.sel && !stb.drive);

  // R5: write enable only inside a driven, selected cycle.
  a_r5_we_inside_sel: assert property (@(posedge clk) disable iff (!rstN)
    stb.we |-> stb.sel && stb.drive);

  // R1: power-up interval keeps every strobe inactive.
  a_r1_pwrup_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRUP) |-> stb == '0);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ram_strobe_t       stb,
  input  logic              load,
  input  logic              capture,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramSelN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [LANES-1:0]  ramByteEnN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic              writeQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
      writeQ <= 1'b0;
    end else if (load) begin
      addrQ  <= reqAddr;
      dataQ  <= reqWdata;
      maskQ  <= reqMask;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= capture;
      if (capture) rdataQ <= ramDqIn;
    end
  end

  assign rspValid = rspQ;
  assign rspData  = rdataQ;
  assign ramAddr  = addrQ;
  assign ramDqOut = dataQ;
  assign ramSelN  = ~stb.sel;
  assign ramOeN   = ~stb.oe;
  assign ramWeN   = ~stb.we;
  assign ramDqOe  = stb.drive;

  // Reads open every lane; writes open only the masked lanes.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ramByteEnN[i] = ~(stb.sel & (~writeQ | maskQ[i]));
  end

  // R9: bus never driven against RAM outputs.
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> !ramDqOe);

  // R9: data is driven whenever a write pulse is active.
  a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> ramDqOe && !ramSelN);

  // R5: address and data hold still across the write pulse.
  a_r5_stable_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN && $past(!ramWeN)) |-> $stable(ramAddr) && $stable(ramDqOut));

  // R5: write ends with select and write enable released together.
  a_r5_joint_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> ramSelN);

  // R3: read strobes come with both lanes open and write enable high.
  a_r3_read_lanes: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> ramWeN && (ramByteEnN == '0));

  // R4: response lasts a single cycle and arrives with select released.
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r4_after_release: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ramSelN);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 4,
  parameter int T_RC_NS    = 70,
  parameter int T_AA_NS    = 70,
  parameter int T_OE_NS    = 25,
  parameter int T_WC_NS    = 70,
  parameter int T_WP_NS    = 50,
  parameter int T_CW_NS    = 60,
  parameter int T_DW_NS    = 20,
  parameter int T_CP_NS    = 10,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramSelN,
  output logic                ramOeN,
  output logic                ramWeN,
  output logic [DATA_W/8-1:0] ramByteEnN,
  output logic [DATA_W-1:0]   ramDqOut,
  output logic                ramDqOe,
  input  logic [DATA_W-1:0]   ramDqIn
);

  localparam int LANES = DATA_W / 8;

  localparam int RD_CYC = max2(1, max2(nsToCycles(T_RC_NS, CLK_NS),
                                 max2(nsToCycles(T_AA_NS, CLK_NS), nsToCycles(T_OE_NS, CLK_NS))));
  localparam int WR_PULSE_CYC = max2(1, max2(max2(nsToCycles(T_WP_NS, CLK_NS), nsToCycles(T_DW_NS, CLK_NS)),
                                        max2(nsToCycles(T_CW_NS, CLK_NS) - 1, nsToCycles(T_WC_NS, CLK_NS) - 1)));
  localparam int GAP_CYC   = max2(1, nsToCycles(T_CP_NS, CLK_NS));
  localparam int PWRUP_CYC = max2(1, nsToCycles(T_PWRUP_NS, CLK_NS));
  localparam int MAX_CYC   = max2(max2(RD_CYC, WR_PULSE_CYC), max2(GAP_CYC, PWRUP_CYC));
  localparam int CW        = max2(1, $clog2(MAX_CYC + 1));

  ram_strobe_t stb;
  logic        load;
  logic        capture;

  sram_ctrl_fsm #(
    .RD_CYC       (RD_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .GAP_CYC      (GAP_CYC),
    .PWRUP_CYC    (PWRUP_CYC),
    .CW           (CW)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqMaskAny (|reqMask),
    .reqReady   (reqReady),
    .stb        (stb),
    .load       (load),
    .capture    (capture)
  );

  sram_ctrl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .load       (load),
    .capture    (capture),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqMask    (reqMask),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .ramAddr    (ramAddr),
    .ramSelN    (ramSelN),
    .ramOeN     (ramOeN),
    .ramWeN     (ramWeN),
    .ramByteEnN (ramByteEnN),
    .ramDqOut   (ramDqOut),
    .ramDqOe    (ramDqOe),
    .ramDqIn    (ramDqIn)
  );

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_NS = 4;
  localparam int PWR_NS = 2000;
  localparam int P_CYC  = 500;  // ceil(2000/4)
  localparam int RD     = 18;   // ceil(70/4)
  localparam int WP     = 17;   // max(13, 5, 15-1, 18-1)
  localparam int GAP    = 3;    // ceil(10/4)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic [17:0] ramAddr;
  logic        ramSelN, ramOeN, ramWeN, ramDqOe;
  logic [1:0]  ramByteEnN;
  logic [15:0] ramDqOut;
  logic [15:0] ramDqIn = 16'hBAD0;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .T_PWRUP_NS(PWR_NS)) i_sram_async_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .ramAddr(ramAddr), .ramSelN(ramSelN),
    .ramOeN(ramOeN), .ramWeN(ramWeN), .ramByteEnN(ramByteEnN), .ramDqOut(ramDqOut),
    .ramDqOe(ramDqOe), .ramDqIn(ramDqIn)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mergeWord(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  // RAM model and expected contents.
  logic [15:0] ramMem [int];
  logic [15:0] expMem [int];

  function automatic logic [15:0] ramRd(input int a);
    return ramMem.exists(a) ? ramMem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] expRd(input int a);
    return expMem.exists(a) ? expMem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!ramSelN && !ramWeN)
      ramMem[int'(ramAddr)] = mergeWord(ramRd(int'(ramAddr)), ramDqOut, ~ramByteEnN);
    ramDqIn <= (!ramSelN && !ramOeN) ? ramRd(int'(ramAddr)) : 16'hBAD0;
  end

  // Pin monitor.
  bit          monOn = 1'b0;
  bit          firstAccess = 1'b1;
  bit          curWrite = 1'b0;
  logic [17:0] curAddr = '0;
  logic [15:0] curData = '0;
  logic [1:0]  curMask = '0;
  int oeRun = 0, weRun = 0, selHigh = 0;
  logic weNPrev = 1'b1, oeNPrev = 1'b1, selNPrev = 1'b1;

  always @(negedge clk) begin
    if (monOn) begin
      if (!ramSelN) check(!reqReady, "R2 ready low during access", 32'(reqReady), 0);
      if (!ramOeN) begin
        oeRun++;
        check(!ramDqOe, "R9 no drive during read", 32'(ramDqOe), 0);
        check(ramWeN && ramByteEnN == 2'b00, "R3 read strobes", {ramWeN, ramByteEnN}, 3'b100);
      end else if (!oeNPrev) begin
        check(oeRun == RD, "R3 read strobe length", oeRun, RD);
        oeRun = 0;
      end
      if (!ramWeN) begin
        weRun++;
        check(ramDqOe, "R9 drive during write", 32'(ramDqOe), 1);
        check(ramByteEnN == ~curMask, "R6 lane enables", ramByteEnN, ~curMask);
        check(ramDqOut == curData && ramAddr == curAddr, "R5 write addr/data", ramDqOut, curData);
      end else if (!weNPrev) begin
        check(weRun == WP, "R5 write pulse length", weRun, WP);
        check(ramSelN, "R5 select released with write enable", 32'(ramSelN), 1);
        weRun = 0;
      end
      if (!ramSelN && selNPrev) begin
        if (firstAccess) check(selHigh >= P_CYC, "R1 select high through power-up", selHigh, P_CYC);
        else check(selHigh >= GAP, "R8 select gap", selHigh, GAP);
        firstAccess = 1'b0;
        selHigh = 0;
        if (curWrite) check(ramWeN && ramDqOe, "R5 setup cycle", {ramWeN, ramDqOe}, 2'b11);
      end
      if (ramSelN) selHigh++;
      weNPrev  = ramWeN;
      oeNPrev  = ramOeN;
      selNPrev = ramSelN;
    end
  end

  task automatic offer(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    curWrite = wr; curAddr = a; curData = d; curMask = m;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = ~a; reqWdata = ~d;  // fields must be ignored after acceptance
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    offer(1'b1, a, d, m);
    expMem[int'(a)] = mergeWord(expRd(int'(a)), d, m);
    if (m == 2'b00) begin
      for (int i = 0; i < 5; i++) begin
        check(ramSelN && ramWeN && reqReady, "R7 zero mask no cycle", {ramSelN, ramWeN, reqReady}, 3'b111);
        @(negedge clk);
      end
    end else begin
      while (!reqReady) @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [17:0] a);
    int n;
    offer(1'b0, a, 16'h0, 2'b00);
    n = 1;
    while (!rspValid) begin @(negedge clk); n++; end
    check(n == RD + 1, "R4 response latency", n, RD + 1);
    check(rspData == expRd(int'(a)), "R4 read data", rspData, expRd(int'(a)));
    check(ramSelN, "R4 response after release", 32'(ramSelN), 1);
    @(negedge clk);
    check(!rspValid, "R4 single-cycle response", 32'(rspValid), 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    check(ramSelN && ramWeN && !ramDqOe && !reqReady, "R1 reset state",
          {ramSelN, ramWeN, ramDqOe, reqReady}, 4'b1100);
    monOn = 1'b1;
    rstN = 1'b1;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!reqReady) check(ramSelN && !ramDqOe, "R1 quiet during power-up", {ramSelN, ramDqOe}, 2'b10);
    end while (!reqReady && n < P_CYC + 20);
    check(n == P_CYC, "R1 power-up length", n, P_CYC);

    // Directed corners.
    doWrite(18'h00000, 16'hA55A, 2'b11);
    doRead (18'h00000);
    doWrite(18'h3FFFF, 16'h1234, 2'b11);
    doWrite(18'h3FFFF, 16'hEEFF, 2'b01);
    doRead (18'h3FFFF);                     // R6 expect 12FF
    doWrite(18'h3FFFF, 16'h77CC, 2'b10);
    doRead (18'h3FFFF);                     // R6 expect 77FF
    doWrite(18'h00000, 16'hFFFF, 2'b00);    // R7
    doRead (18'h00000);
    doRead (18'h00001);
    doRead (18'h00001);

    // Constrained random mix.
    for (int k = 0; k < 200; k++) begin
      logic [17:0] a;
      logic [1:0]  m;
      a = 18'(($urandom % 24) * 11397);
      m = 2'($urandom);
      if ($urandom % 2) doWrite(a, 16'($urandom), m);
      else              doRead(a);
    end

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule